// File: doc/BRIEF.md
# Serial/Parallel Nibble Entry Register

This block is the entry stage of a 4-bit-wide buffer. It collects one nibble, either in one parallel load or one bit at a time on a gated serial clock. It lowers an active-low full flag once a complete nibble is held. When the downstream stack's top slot is free, it hands the nibble over with a single write strobe.

A marker bit is preloaded at the head of a five-stage chain: four data stages and a completion stage. Each serial shift moves the marker one place. When the marker reaches the completion stage, the nibble is complete and more serial clocks have no effect. A parallel load fills the four data stages and sets the completion stage at once.

A transfer request that is held low starts at most one write per word. A done latch records the write. The latch, and the re-initialisation of the register, are held off while the parallel load strobe stays high. Tying the full flag to the transfer request gives automatic entry. All asynchronous strobes and data go through two-flop synchronisers onto the system clock.

Top module: `sp_entry_reg`

## Requirements
- R1: While `rst_n` is low, the chain is initialised: `nibble` reads 4'b1000 (the head stage set, all others clear), `full_n` is 1 and `stack_wr` is 0.
- R2: With `ser_en_n` low, each high-to-low transition of `ser_clk` shifts `ser_din` in at bit 3 and moves every stage one place toward bit 0. After four transitions, the first bit is in bit 0, the fourth bit is in bit 3, and `full_n` goes low. After three transitions, `nibble` reads {b2,b1,b0,1} and `full_n` is still high.
- R3: Serial clock transitions made while `ser_en_n` is high leave `nibble` and `full_n` unchanged.
- R4: Once the register is full, further serial clock transitions leave `nibble` unchanged.
- R5: While `load` is high (and no write of the current word has happened), `nibble` takes `din` and `full_n` goes low.
- R6: When `xfer_n` is low, the register is full and `stack_ready` is high, `stack_wr` is high for exactly one cycle. The register then re-initialises: `full_n` returns to 1 and `nibble` to 4'b1000.
- R7: While `stack_ready` is low, no write occurs and the register stays full.
- R8: A word produces only one write, even if `xfer_n` and `full_n` both stay low.
- R9: After a write, re-initialisation waits until `load` is low. Until then `full_n` stays low.
- R10: With `full_n` tied to `xfer_n`, each completed nibble (serial or parallel) is written once with no other control.
- R11: While `stack_wr` is high, `nibble` shows the word being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low |
| load | input | 1 | Parallel load strobe, active high, asynchronous |
| din | input | 4 | Parallel data |
| ser_din | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, acts on its falling transition |
| ser_en_n | input | 1 | Serial enable, active low |
| xfer_n | input | 1 | Transfer-to-stack request, active low, synchronous |
| stack_ready | input | 1 | Stack top slot is empty |
| nibble | output | 4 | Held word |
| stack_wr | output | 1 | One-cycle stack write strobe |
| full_n | output | 1 | Register full, active low |

## Verification
The bench checks the partial serial word after three shifts, where {b2,b1,b0,1} exposes a chain that shifts the wrong way or drops the marker. It sends extra serial edges after the word is complete, which a design without the full gate would use to corrupt the data. It holds `xfer_n` low together with a long `load` pulse: a design without the done latch writes the word repeatedly, and one that re-initialises early raises `full_n` while `load` is still high. It also runs with `stack_ready` low, where a design that ignores the stack state would write into an occupied slot. A scoreboard compares every written word against the queue of expected words.

// File: rtl/sp_entry_pkg.sv
`timescale 1ns/1ps
package sp_entry_pkg;
  localparam int NIB_W   = 4;
  localparam int CHAIN_W = NIB_W + 1;

  // bit 0 is the completion stage, bits CHAIN_W-1:1 the data stages
  typedef logic [CHAIN_W-1:0] chain_t;

  function automatic chain_t chain_init();
    chain_t c;
    c = '0;
    c[CHAIN_W-1] = 1'b1;
    return c;
  endfunction

  function automatic chain_t chain_shift(input chain_t c, input logic b);
    return {b, c[CHAIN_W-1:1]};
  endfunction

  function automatic chain_t chain_load(input logic [NIB_W-1:0] d);
    return {d, 1'b1};
  endfunction

  function automatic logic chain_full(input chain_t c);
    return c[0];
  endfunction

  function automatic logic [NIB_W-1:0] chain_data(input chain_t c);
    return c[CHAIN_W-1:1];
  endfunction
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
module sp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOT = W * STAGES;
  logic [TOT-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= RST_VAL;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[TOT-W-1:0], d};
      end
    end
  endgenerate

  assign q = sh[TOT-1 -: W];
endmodule

// File: rtl/sp_chain.sv
`timescale 1ns/1ps
module sp_chain
  import sp_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reinit,
  input  logic             load_lvl,
  input  logic [NIB_W-1:0] load_data,
  input  logic             shift_ev,
  input  logic             shift_bit,
  output chain_t           chain_q,
  output logic             full
);
  chain_t chain_d;

  always_comb begin
    chain_d = chain_q;
    if (reinit)
      chain_d = chain_init();
    else if (load_lvl)
      chain_d = chain_load(load_data);
    else if (shift_ev && !chain_full(chain_q))
      chain_d = chain_shift(chain_q, shift_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= chain_init();
    else        chain_q <= chain_d;
  end

  assign full = chain_full(chain_q);

  // R1: state seen at the first edge after reset release is the initial one
  a_r1_reset_init: assert property (@(posedge clk)
    $rose(rst_n) |-> (chain_q == chain_init()));

  // R4: a full word only changes by reload or re-initialisation
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !reinit && !load_lvl) |=> $stable(chain_q));
endmodule

// File: rtl/sp_xfer_ctrl.sv
`timescale 1ns/1ps
module sp_xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_n,
  input  logic full,
  input  logic stack_ready,
  input  logic load_s,
  output logic stack_wr,
  output logic done_q,
  output logic reinit
);
  logic wr_fire;

  assign wr_fire = !xfer_n && full && stack_ready && !done_q;
  assign reinit  = done_q && !load_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      stack_wr <= 1'b0;
    end else begin
      stack_wr <= wr_fire;
      if (wr_fire)     done_q <= 1'b1;
      else if (reinit) done_q <= 1'b0;
    end
  end

  // R6: write strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stack_wr |=> !stack_wr);

  // R7: a write needs a full word, a request and a free stack slot
  a_r7_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stack_wr |-> $past(stack_ready && full && !xfer_n));

  // R9: while load stays high after a write, the word remains full
  a_r9_hold_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && load_s) |=> full);

  // R6: once load is low after a write, the register empties
  a_r6_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load_s) |=> !full);
endmodule

// File: rtl/sp_entry_reg.sv
`timescale 1ns/1ps
module sp_entry_reg
  import sp_entry_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NIB_W-1:0] din,
  input  logic             ser_din,
  input  logic             ser_clk,
  input  logic             ser_en_n,
  input  logic             xfer_n,
  input  logic             stack_ready,
  output logic [NIB_W-1:0] nibble,
  output logic             stack_wr,
  output logic             full_n
);
  localparam int SW = NIB_W + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(2);  // serial enable idles high

  logic [SW-1:0]    raw_in, syn;
  logic [NIB_W-1:0] din_s;
  logic             sclk_s, sdin_s, sen_n_s, load_s;
  logic             sclk_prev, sclk_fall, shift_ev;
  logic             done_q, reinit, full, load_lvl;
  chain_t           chain_q;

  assign raw_in = {din, ser_clk, ser_din, ser_en_n, load};

  sp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign {din_s, sclk_s, sdin_s, sen_n_s, load_s} = syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_fall = sclk_prev && !sclk_s;
  assign shift_ev  = sclk_fall && !sen_n_s && !load_s;
  assign load_lvl  = load_s && !done_q;

  sp_chain i_chain (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .load_lvl(load_lvl),
    .load_data(din_s), .shift_ev(shift_ev), .shift_bit(sdin_s),
    .chain_q(chain_q), .full(full));

  sp_xfer_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .full(full),
    .stack_ready(stack_ready), .load_s(load_s), .stack_wr(stack_wr),
    .done_q(done_q), .reinit(reinit));

  assign nibble = chain_data(chain_q);
  assign full_n = !full;

  // R3: a disabled serial clock never moves a partial word
  a_r3_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && sen_n_s && !load_s && !done_q) |=> $stable(nibble));

  // R2: a shift into a partial word takes the synchronised data bit at the head
  a_r2_head_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !full && !done_q) |=> (nibble[NIB_W-1] == $past(sdin_s)));
endmodule

// File: tb/test_sp_entry_reg.sv
`timescale 1ns/1ps
module test_sp_entry_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, ser_din = 0, ser_clk = 0, ser_en_n = 1;
  logic xfer_man = 1, auto_mode = 0, stack_ready = 1;
  logic [3:0] din = 0;
  logic [3:0] nibble;
  logic stack_wr, full_n, xfer_n;
  int n_checks = 0, n_fail = 0, wr_count = 0;
  bit finished = 0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;
  assign xfer_n = auto_mode ? full_n : xfer_man;

  sp_entry_reg i_sp_entry_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .ser_din(ser_din),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .xfer_n(xfer_n),
    .stack_ready(stack_ready), .nibble(nibble), .stack_wr(stack_wr),
    .full_n(full_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_din = b; wait_n(3);
    ser_clk = 1; wait_n(3);
    ser_clk = 0; wait_n(6);
  endtask

  task automatic par_load(input logic [3:0] d);
    din = d; load = 1; wait_n(5);
    load = 0; wait_n(5);
  endtask

  // monitor: every write is compared against the scoreboard (R11)
  always @(negedge clk) begin
    if (rst_n && stack_wr) begin
      wr_count++;
      if (exp_q.size() == 0)
        chk(1'b0, "R8 unexpected write", int'(nibble), 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(nibble == e, "R11 written word", int'(nibble), int'(e));
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int base;
    wait_n(3);
    chk(nibble == 4'h8, "R1 reset nibble", nibble, 8);
    chk(full_n == 1'b1, "R1 reset full_n", full_n, 1);
    chk(stack_wr == 1'b0, "R1 reset stack_wr", stack_wr, 0);
    rst_n = 1; wait_n(4);

    // R3: disabled serial clocks
    ser_en_n = 1; ser_bit(0); ser_bit(1);
    chk(nibble == 4'h8, "R3 nibble unchanged", nibble, 8);
    chk(full_n == 1'b1, "R3 still empty", full_n, 1);

    // R2: serial word b0..b3 = 1,0,1,1
    ser_en_n = 0;
    ser_bit(1); ser_bit(0); ser_bit(1);
    chk(nibble == 4'hB, "R2 partial word", nibble, 4'hB);
    chk(full_n == 1'b1, "R2 not yet full", full_n, 1);
    ser_bit(1);
    chk(nibble == 4'hD, "R2 full word", nibble, 4'hD);
    chk(full_n == 1'b0, "R2 full flag", full_n, 0);

    // R4: extra edges ignored
    ser_bit(0); ser_bit(0);
    chk(nibble == 4'hD, "R4 held after full", nibble, 4'hD);
    ser_en_n = 1;

    // R7: stack busy
    base = wr_count;
    stack_ready = 0; xfer_man = 0; wait_n(10);
    chk(wr_count == base, "R7 no write while busy", wr_count - base, 0);
    chk(full_n == 1'b0, "R7 stays full", full_n, 0);

    // R6: write and re-initialise
    exp_q.push_back(4'hD);
    stack_ready = 1; wait_n(8); xfer_man = 1; wait_n(2);
    chk(wr_count == base + 1, "R6 one write", wr_count - base, 1);
    chk(full_n == 1'b1, "R6 emptied", full_n, 1);
    chk(nibble == 4'h8, "R6 re-initialised", nibble, 8);

    // R5: parallel load
    par_load(4'h6);
    chk(nibble == 4'h6, "R5 parallel data", nibble, 6);
    chk(full_n == 1'b0, "R5 full flag", full_n, 0);
    exp_q.push_back(4'h6);
    base = wr_count;
    xfer_man = 0; wait_n(6); xfer_man = 1; wait_n(2);
    chk(wr_count == base + 1, "R6 parallel word written", wr_count - base, 1);

    // R8 / R9: request held low across a long load
    base = wr_count;
    exp_q.push_back(4'hA);
    xfer_man = 0; din = 4'hA; load = 1; wait_n(12);
    chk(wr_count == base + 1, "R8 single write", wr_count - base, 1);
    chk(full_n == 1'b0, "R9 held full during load", full_n, 0);
    load = 0; wait_n(8);
    chk(full_n == 1'b1, "R9 emptied after load", full_n, 1);
    chk(wr_count == base + 1, "R8 still one write", wr_count - base, 1);
    xfer_man = 1; wait_n(3);

    // R10: automatic entry
    base = wr_count;
    auto_mode = 1;
    exp_q.push_back(4'h3);
    par_load(4'h3); wait_n(4);
    exp_q.push_back(4'h9);
    ser_en_n = 0;
    ser_bit(1); ser_bit(0); ser_bit(0); ser_bit(1);
    ser_en_n = 1; wait_n(6);
    chk(wr_count == base + 2, "R10 two auto writes", wr_count - base, 2);
    chk(full_n == 1'b1, "R10 empty at end", full_n, 1);
    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule